// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts one pulse-width command into two gate enables for the high-side and low-side switches of a synchronous buck stage. The two enables are never high together. The dead time between them is not a fixed count. Each gate turns on only after a feedback flag from the opposite side confirms that the other switch has really turned off. For the high side, that flag says the low-side gate voltage is below its turn-off level. For the low side, it says the switch node has fallen below its low threshold.

The pulse-width command arrives as two comparator flags, one above the rising threshold and one below the falling threshold. Together they give a three-level input. When the level sits between the two thresholds long enough, both gates shut down. If the switch node never falls after the high side is released, a timeout turns the low side on anyway so that the bootstrap supply stays charged. If the node then stays high for a long period, a fault latch holds both gates off until the next rising command edge. A supply-good flag gates all of this.

Every input is asynchronous and passes through a two-flop synchronizer. All time limits are parameters counted in clock cycles.

Top module: `gseq_top`

## Requirements
- R1: While the synchronized supply-good flag is false, both enables are low and the status is 0. A supply drop is seen at the outputs exactly three clock edges after the input changes (two synchronizer edges plus the state register). While the supply is low, changes of the command are ignored.
- R2: After the supply-good flag returns, the command takes control again: a high command leads to the high side on (status 3).
- R3: On a command that goes high, the low-side enable falls first. The high-side enable rises only on an edge where the synchronized low-gate-off flag is true, and it stays low for as long as that flag is false. The two enables are never high in the same cycle.
- R4: On a command that goes low, the high-side enable falls first. The low-side enable rises on the first edge at which the synchronized switch-node-low flag is true. When that flag is already true, the low-side enable rises exactly one cycle after the high-side enable falls.
- R5: If the switch-node-low flag stays false, the low-side enable is forced on exactly `TO_CYC` cycles after the high-side enable falls.
- R6: After a forced turn-on, if the switch node stays high for `FLT_CYC` consecutive cycles, the low-side enable drops after being high for exactly `FLT_CYC` cycles and the status becomes 6. Once the switch node is seen low, monitoring of the forced turn-on ends and no fault is raised.
- R7: In the fault state, both enables stay low. The block leaves this state only on a rising command edge (a move into the high level from any other level), and a command in the shutdown window does not release it. A supply drop still takes it to status 0.
- R8: A command in the shutdown window (neither flag set) causes shutdown (status 5, both enables low) if and only if it lasts at least `HOLD_CYC`+1 consecutive synchronized cycles. Shorter excursions leave the gates unchanged.
- R9: Shutdown clears as soon as the command leaves the window. A low level then leads to the low side on (status 1), and a high level leads to the high side on (status 3).
- R10: Decoding and status. The above-rising flag alone means high. The below-falling flag means low and takes priority when both flags are set. Neither flag means the window. The status codes are: 0 off, 1 low side on, 2 waiting for the low gate to fall, 3 high side on, 4 waiting for the switch node to fall, 5 shutdown, 6 switch-node fault.
- R11: A command edge driven between clock edges changes the low-side enable at the third following clock edge. The high side (with the low-gate flag already true) follows at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_above_i | input | 1 | Command is above the rising threshold (asynchronous) |
| pwm_below_i | input | 1 | Command is below the falling threshold (asynchronous) |
| lg_off_i | input | 1 | Low-side gate voltage is below its turn-off level (asynchronous) |
| sw_low_i | input | 1 | Switch node is below its low threshold (asynchronous) |
| supply_ok_i | input | 1 | Supply-good flag (asynchronous) |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Status code, per R10 |

## Verification
The bench sweeps the length of a shutdown-window excursion across the holdoff limit. A counter that is off by one would shut down one cycle too early or too late, and a counter that is not cleared would shut down after the excursions add up. It measures the gap between the two enables, both with the switch-node flag already present and with it stuck false. A wrong timeout count, or a low side that skips the handshake, would show as a gap other than 1 or `TO_CYC`. It times the forced-on fault interval exactly. It also checks that a single low reading of the switch node cancels the fault, and that only a true rising edge (not a window excursion) releases the latch. A latch that released early would let the high side turn on while the command is still low.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_LOW     = 3'd1,
        ST_WAIT_LG = 3'd2,
        ST_HIGH    = 3'd3,
        ST_WAIT_SW = 3'd4,
        ST_SHUT    = 3'd5,
        ST_FAULT   = 3'd6
    } gseq_state_e;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_MID  = 2'd2
    } pwm_lvl_e;
endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
    parameter int W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            s1_d[b] = async_i[b];
            s2_d[b] = s1_q[b];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                s1_q[b] <= 1'b0;
                s2_q[b] <= 1'b0;
            end else begin
                s1_q[b] <= s1_d[b];
                s2_q[b] <= s2_d[b];
            end
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/gseq_pwm_window.sv
module gseq_pwm_window
    import gseq_pkg::*;
#(
    parameter int HOLD_CYC = 23
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     above_i,
    input  logic     below_i,
    output pwm_lvl_e lvl_o,
    output logic     shut_o,
    output logic     rise_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] wcnt;
        logic          was_high;
    } win_regs_t;

    win_regs_t r_q, r_d;
    pwm_lvl_e  lvl;

    always_comb begin
        if (below_i)       lvl = LVL_LOW;
        else if (above_i)  lvl = LVL_HIGH;
        else               lvl = LVL_MID;
    end

    always_comb begin
        r_d          = r_q;
        r_d.was_high = (lvl == LVL_HIGH);
        if (lvl == LVL_MID) begin
            if (r_q.wcnt != CW'(HOLD_CYC)) r_d.wcnt = r_q.wcnt + 1'b1;
        end else begin
            r_d.wcnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign lvl_o  = lvl;
    assign shut_o = (lvl == LVL_MID) && (r_q.wcnt == CW'(HOLD_CYC));
    assign rise_o = (lvl == LVL_HIGH) && !r_q.was_high;
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
    import gseq_pkg::*;
#(
    parameter int TO_CYC  = 25,
    parameter int FLT_CYC = 200
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  pwm_lvl_e   lvl_i,
    input  logic       shut_i,
    input  logic       rise_i,
    input  logic       lg_off_i,
    input  logic       sw_low_i,
    input  logic       sup_ok_i,
    output logic       hs_en_o,
    output logic       ls_en_o,
    output logic [2:0] state_o
);
    localparam int TW = $clog2(TO_CYC + 1);
    localparam int FW = $clog2(FLT_CYC + 1);

    typedef struct packed {
        gseq_state_e   state;
        logic [TW-1:0] tcnt;
        logic [FW-1:0] fcnt;
        logic          forced;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!sup_ok_i) begin
            r_d.state  = ST_OFF;
            r_d.tcnt   = '0;
            r_d.fcnt   = '0;
            r_d.forced = 1'b0;
        end else if (r_q.state == ST_FAULT) begin
            if (rise_i) r_d.state = ST_WAIT_LG;
        end else if (shut_i) begin
            r_d.state  = ST_SHUT;
            r_d.tcnt   = '0;
            r_d.fcnt   = '0;
            r_d.forced = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_OFF, ST_SHUT: begin
                    if (lvl_i == LVL_HIGH) begin
                        r_d.state = ST_WAIT_LG;
                    end else if (lvl_i == LVL_LOW) begin
                        r_d.state = ST_WAIT_SW;
                        r_d.tcnt  = '0;
                    end
                end
                ST_LOW: begin
                    if (lvl_i == LVL_HIGH) begin
                        r_d.state  = ST_WAIT_LG;
                        r_d.forced = 1'b0;
                        r_d.fcnt   = '0;
                    end else if (r_q.forced) begin
                        if (sw_low_i) begin
                            r_d.forced = 1'b0;
                            r_d.fcnt   = '0;
                        end else if (r_q.fcnt == FW'(FLT_CYC - 1)) begin
                            r_d.state  = ST_FAULT;
                            r_d.forced = 1'b0;
                            r_d.fcnt   = '0;
                        end else begin
                            r_d.fcnt = r_q.fcnt + 1'b1;
                        end
                    end
                end
                ST_WAIT_LG: begin
                    if (lvl_i == LVL_LOW) begin
                        r_d.state = ST_WAIT_SW;
                        r_d.tcnt  = '0;
                    end else if (lg_off_i) begin
                        r_d.state = ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (lvl_i == LVL_LOW) begin
                        r_d.state = ST_WAIT_SW;
                        r_d.tcnt  = '0;
                    end
                end
                ST_WAIT_SW: begin
                    if (lvl_i == LVL_HIGH) begin
                        r_d.state = ST_WAIT_LG;
                        r_d.tcnt  = '0;
                    end else if (sw_low_i) begin
                        r_d.state  = ST_LOW;
                        r_d.forced = 1'b0;
                        r_d.tcnt   = '0;
                    end else if (r_q.tcnt == TW'(TO_CYC - 1)) begin
                        r_d.state  = ST_LOW;
                        r_d.forced = 1'b1;
                        r_d.fcnt   = '0;
                        r_d.tcnt   = '0;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                default: begin
                    r_d.state = ST_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state  <= ST_OFF;
            r_q.tcnt   <= '0;
            r_q.fcnt   <= '0;
            r_q.forced <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_en_o = (r_q.state == ST_HIGH);
    assign ls_en_o = (r_q.state == ST_LOW);
    assign state_o = r_q.state;
endmodule

// File: rtl/gseq_top.sv
module gseq_top
    import gseq_pkg::*;
#(
    parameter int TO_CYC   = 25,
    parameter int HOLD_CYC = 23,
    parameter int FLT_CYC  = 200
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwm_above_i,
    input  logic       pwm_below_i,
    input  logic       lg_off_i,
    input  logic       sw_low_i,
    input  logic       supply_ok_i,
    output logic       hs_en_o,
    output logic       ls_en_o,
    output logic [2:0] state_o
);
    localparam int NIN = 5;

    logic [NIN-1:0] raw, syn;
    logic           above_s, below_s, lg_s, sw_s, sup_s;
    pwm_lvl_e       lvl;
    logic           shut, rise, win_s;

    assign raw = {supply_ok_i, sw_low_i, lg_off_i, pwm_below_i, pwm_above_i};
    assign {sup_s, sw_s, lg_s, below_s, above_s} = syn;

    gseq_sync #(.W(NIN)) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .async_i(raw),
        .sync_o(syn)
    );

    gseq_pwm_window #(.HOLD_CYC(HOLD_CYC)) i_win (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .above_i(above_s),
        .below_i(below_s),
        .lvl_o  (lvl),
        .shut_o (shut),
        .rise_o (rise)
    );

    assign win_s = (lvl == LVL_MID);

    gseq_fsm #(.TO_CYC(TO_CYC), .FLT_CYC(FLT_CYC)) i_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lvl_i   (lvl),
        .shut_i  (shut),
        .rise_i  (rise),
        .lg_off_i(lg_s),
        .sw_low_i(sw_s),
        .sup_ok_i(sup_s),
        .hs_en_o (hs_en_o),
        .ls_en_o (ls_en_o),
        .state_o (state_o)
    );
endmodule

// File: rtl/gseq_checker.sv
module gseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hs,
    input logic       ls,
    input logic [2:0] state,
    input logic       sup_s,
    input logic       lg_s,
    input logic       win_s
);
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && ls));

    p_supply_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!hs && !ls && state == 3'd0));

    p_hs_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs) |-> $past(lg_s));

    p_ls_after_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls) |-> !$past(hs));

    p_fault_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd6) |=> (state == 3'd6 || state == 3'd2 || state == 3'd0));

    p_shut_from_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == 3'd5) |-> $past(win_s));
endmodule

bind gseq_top gseq_checker i_chk (
    .clk  (clk_i),
    .rst_n(rst_ni),
    .hs   (hs_en_o),
    .ls   (ls_en_o),
    .state(state_o),
    .sup_s(sup_s),
    .lg_s (lg_s),
    .win_s(win_s)
);

// File: tb/test_gseq_top.sv
module test_gseq_top;
    localparam int TO   = 8;
    localparam int HOLD = 6;
    localparam int FLT  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b1, lg_off = 1'b1, sw_low = 1'b1, sup = 1'b0;
    logic hs, ls;
    logic [2:0] st;

    int n_chk = 0;
    int n_bad = 0;
    logic saw_shut = 1'b0;
    logic saw_on   = 1'b0;
    logic done     = 1'b0;

    always #5 clk = ~clk;

    gseq_top #(.TO_CYC(TO), .HOLD_CYC(HOLD), .FLT_CYC(FLT)) i_gseq_top (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pwm_above_i(above),
        .pwm_below_i(below),
        .lg_off_i   (lg_off),
        .sw_low_i   (sw_low),
        .supply_ok_i(sup),
        .hs_en_o    (hs),
        .ls_en_o    (ls),
        .state_o    (st)
    );

    always @(negedge clk) begin
        if (st == 3'd5) saw_shut <= 1'b1;
        if (hs || ls)   saw_on   <= 1'b1;
        if (hs && ls) begin
            n_chk++; n_bad++;
            $display("FAIL R3: overlap hs=%0b ls=%0b expected not both", hs, ls);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pwm(input logic a, input logic b);
        above = a; below = b;
    endtask

    task automatic wait_state(input logic [2:0] s, input int lim, output int ok);
        ok = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (st == s) begin ok = 1; break; end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        cyc(20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        int ok, gap, dur;
        // Reset state (R1)
        cyc(3);
        check("R1 reset status", st, 0);
        check("R1 reset gates", {hs, ls}, 0);
        rst_n = 1'b1;
        cyc(5);
        check("R1 supply low status", st, 0);
        check("R1 supply low gates", {hs, ls}, 0);

        // R2: supply returns, low command -> low side on
        sup = 1'b1;
        wait_state(3'd1, 20, ok);
        check("R2 low side after supply", ok, 1);

        // R11: latency of a rising command
        set_pwm(1'b1, 1'b0);
        cyc(2);
        check("R11 ls still on after 2 edges", ls, 1);
        cyc(1);
        check("R11 ls off at 3rd edge", {hs, ls}, 0);
        check("R10 status wait low gate", st, 2);
        cyc(1);
        check("R11 hs on at 4th edge", hs, 1);
        check("R10 status high", st, 3);

        // R4: falling with switch node already low -> gap 1
        set_pwm(1'b0, 1'b1);
        gap = 0;
        for (int i = 0; i < 20 && hs; i++) @(negedge clk);
        for (int i = 0; i < 50 && !ls; i++) begin
            gap++;
            if (i == 0) check("R10 status wait switch node", st, 4);
            @(negedge clk);
        end
        check("R4 dead gap with node low", gap, 1);

        // R3: rising with low gate flag false -> hs held off
        lg_off = 1'b0;
        set_pwm(1'b1, 1'b0);
        cyc(15);
        check("R3 hs held off without low-gate flag", {hs, ls}, 0);
        check("R3 status waiting", st, 2);
        lg_off = 1'b1;
        cyc(3);
        check("R3 hs after low-gate flag", hs, 1);

        // R5: timeout with switch node stuck high -> gap TO
        sw_low = 1'b0;
        set_pwm(1'b0, 1'b1);
        gap = 0;
        for (int i = 0; i < 20 && hs; i++) @(negedge clk);
        for (int i = 0; i < 100 && !ls; i++) begin gap++; @(negedge clk); end
        check("R5 forced turn-on gap", gap, TO);

        // R6: fault after FLT cycles of node high
        dur = 0;
        for (int i = 0; i < 200 && ls; i++) begin dur++; @(negedge clk); end
        check("R6 forced on duration", dur, FLT);
        check("R6 fault status", st, 6);

        // R7: fault holds through low level and short window
        cyc(30);
        check("R7 fault held", st, 6);
        set_pwm(1'b0, 1'b0);
        cyc(HOLD + 5);
        set_pwm(1'b0, 1'b1);
        cyc(10);
        check("R7 window does not release", st, 6);
        check("R7 gates low in fault", {hs, ls}, 0);
        set_pwm(1'b1, 1'b0);
        wait_state(3'd3, 20, ok);
        check("R7 rising edge releases", ok, 1);

        // R6: one low reading of the node cancels fault monitoring
        set_pwm(1'b0, 1'b1);
        wait_state(3'd1, 50, ok);
        check("R6 forced on again", ok, 1);
        cyc(3);
        sw_low = 1'b1;
        @(negedge clk);
        sw_low = 1'b0;
        cyc(3 * FLT);
        check("R6 no fault after node low", st, 1);
        sw_low = 1'b1;

        // R8: sweep window length across holdoff
        for (int d = 1; d <= HOLD + 3; d++) begin
            cyc(5);
            saw_shut = 1'b0;
            set_pwm(1'b0, 1'b0);
            cyc(d);
            set_pwm(1'b0, 1'b1);
            cyc(10);
            check($sformatf("R8 window len %0d", d), saw_shut, (d >= HOLD + 1) ? 1 : 0);
            check($sformatf("R9 back to low after len %0d", d), st, 1);
        end

        // R9: long window then high
        set_pwm(1'b0, 1'b0);
        cyc(HOLD + 10);
        check("R8 shutdown state", st, 5);
        check("R8 shutdown gates", {hs, ls}, 0);
        set_pwm(1'b1, 1'b0);
        wait_state(3'd3, 20, ok);
        check("R9 exit to high", ok, 1);

        // R10: both flags set decode as low
        set_pwm(1'b1, 1'b1);
        wait_state(3'd1, 20, ok);
        check("R10 both flags -> low", ok, 1);

        // R1: supply drop latency and ignored command
        set_pwm(1'b1, 1'b0);
        wait_state(3'd3, 20, ok);
        sup = 1'b0;
        cyc(2);
        check("R1 still high before 3rd edge", st, 3);
        cyc(1);
        check("R1 off at 3rd edge", st, 0);
        saw_on = 1'b0;
        for (int i = 0; i < 10; i++) begin
            set_pwm(i[0], ~i[0]);
            cyc(4);
        end
        check("R1 command ignored while off", saw_on, 0);

        // R2: supply returns with high command
        set_pwm(1'b1, 1'b0);
        sup = 1'b1;
        wait_state(3'd3, 20, ok);
        check("R2 high side after supply", ok, 1);

        done = 1'b1;
        finish_run();
    end
endmodule